// File: doc/BRIEF.md
# ASID-Tagged Translation Cache with Access Checks

This block caches recent virtual-page-to-physical-frame translations for a core's memory pipeline. Each cached translation carries an address space identifier, so translations that belong to several processes can stay resident together. A context switch therefore needs no flush. Every lookup supplies a virtual address, the current identifier, whether the access is a write, and whether the core runs in user mode. On a hit, the block returns the physical address in the same cycle, together with a fault flag that is raised when the stored permissions forbid the access.

On a miss, the block registers a single walk request and holds it until the page table walker answers. A normal answer installs the translation. A fault answer installs nothing. New lookups are stalled while the request is open. Software-driven maintenance is limited to two operations: dropping one translation selected by page number and identifier, and clearing the whole cache in one cycle.

Top module: `asid_tlb`

## Requirements
- R1: On a hit, `rsp_hit_o` is 1 in the same cycle and `rsp_paddr_o` is the cached frame number concatenated with the 12 low address bits passed through unchanged.
- R2: A hit needs both the page number (address bits 31:12) and `lkp_asid_i` to equal a stored entry; the same page under another identifier misses.
- R3: An accepted miss raises `walk_req_o` from the next cycle, with `walk_vpn_o`/`walk_asid_o` equal to the missed tag, held stable until a fill carrying that same tag arrives; fills for other tags do not end it.
- R4: A fill with `fill_fault_i`=0 installs the translation so a later lookup hits; a fill with `fill_fault_i`=1 ends the request and installs nothing.
- R5: A hit faults (`rsp_fault_o`=1, `rsp_hit_o`=1) when a write meets `writable`=0 or a user-mode access meets `user`=0; reads of read-only pages and supervisor accesses to supervisor-only pages do not fault.
- R6: An invalidate removes only the entry matching both its page number and identifier.
- R7: A flush clears every entry, so the next cycle's lookups all miss.
- R8: A fill whose page number and identifier are already cached overwrites that entry; no duplicate is created.
- R9: A new translation goes into the lowest-numbered free slot; when all 8 slots are full, a round-robin pointer, starting at slot 0 and advancing after each eviction, picks the victim.
- R10: While a walk is open, `lkp_ready_o` is 0 and lookups produce no hit and no new request.
- R11: After reset, the cache is empty, `walk_req_o` is 0 and `lkp_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_vaddr_i | input | VA_W | Virtual address |
| lkp_asid_i | input | ASID_W | Current address space identifier |
| lkp_write_i | input | 1 | Access is a write |
| lkp_user_i | input | 1 | Access made in user mode |
| lkp_ready_o | output | 1 | Lookups accepted (no walk open) |
| rsp_hit_o | output | 1 | Accepted lookup hit |
| rsp_fault_o | output | 1 | Hit violates stored permissions |
| rsp_paddr_o | output | PA_W | Physical address on hit, else zero |
| walk_req_o | output | 1 | Walk request open |
| walk_vpn_o | output | VA_W-12 | Page number to walk |
| walk_asid_o | output | ASID_W | Identifier to walk |
| fill_valid_i | input | 1 | Walker answer |
| fill_vpn_i | input | VA_W-12 | Answered page number |
| fill_asid_i | input | ASID_W | Answered identifier |
| fill_pfn_i | input | PA_W-12 | Frame number |
| fill_writable_i | input | 1 | Page writable |
| fill_user_i | input | 1 | Page reachable from user mode |
| fill_fault_i | input | 1 | No valid mapping; install nothing |
| inv_valid_i | input | 1 | Invalidate one entry |
| inv_vpn_i | input | VA_W-12 | Page number to invalidate |
| inv_asid_i | input | ASID_W | Identifier to invalidate |
| flush_i | input | 1 | Clear all entries |

## Verification
The bench uses the default parameters: 8 entries, 32-bit virtual and physical addresses, and 8-bit identifiers. With only eight slots, a short run can fill the cache completely. That brings both the free-slot preference and the round-robin eviction order into view, including two successive evictions. The bench picks frame numbers whose bitwise OR differs from each value alone. A duplicated tag after an overwrite would then show up as a corrupted physical address.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;
  localparam int unsigned PAGE_OFF_W = 12;

  typedef struct packed {
    logic wr;   // page may be written
    logic usr;  // page reachable from user mode
  } perm_t;
endpackage

// File: rtl/tlb_match.sv
`timescale 1ns/1ps
module tlb_match #(
  parameter int unsigned N      = 8,
  parameter int unsigned VPN_W  = 20,
  parameter int unsigned ASID_W = 8
) (
  input  logic                         en_i,
  input  logic [N-1:0]                 valid_i,
  input  logic [N-1:0][VPN_W-1:0]      vpn_i,
  input  logic [N-1:0][ASID_W-1:0]     asid_i,
  input  logic [VPN_W-1:0]             key_vpn_i,
  input  logic [ASID_W-1:0]            key_asid_i,
  output logic [N-1:0]                 hit_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_o[g] = en_i && valid_i[g] &&
                      (vpn_i[g] == key_vpn_i) && (asid_i[g] == key_asid_i);
  end
endmodule

// File: rtl/tlb_victim.sv
`timescale 1ns/1ps
module tlb_victim #(
  parameter  int unsigned N     = 8,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     valid_i,
  input  logic             alloc_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             free_any;

  // lowest free slot wins
  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign idx_o = free_any ? free_idx : rr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rr_q <= '0;
    else if (alloc_i && !free_any)
      rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
  end

  // R9
  free_slot_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i != '1) |-> !valid_i[idx_o]);
endmodule

// File: rtl/tlb_walk_ctl.sv
`timescale 1ns/1ps
module tlb_walk_ctl #(
  parameter int unsigned VPN_W  = 20,
  parameter int unsigned ASID_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [VPN_W-1:0]  start_vpn_i,
  input  logic [ASID_W-1:0] start_asid_i,
  input  logic              done_i,
  output logic              pending_o,
  output logic [VPN_W-1:0]  vpn_o,
  output logic [ASID_W-1:0] asid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_o <= 1'b0;
      vpn_o     <= '0;
      asid_o    <= '0;
    end else if (start_i) begin
      pending_o <= 1'b1;
      vpn_o     <= start_vpn_i;
      asid_o    <= start_asid_i;
    end else if (done_i) begin
      pending_o <= 1'b0;
    end
  end

  // R3
  walk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_o && !done_i) |=> (pending_o && $stable(vpn_o) && $stable(asid_o)));
endmodule

// File: rtl/asid_tlb.sv
`timescale 1ns/1ps
module asid_tlb #(
  parameter  int unsigned N      = 8,
  parameter  int unsigned VA_W   = 32,
  parameter  int unsigned PA_W   = 32,
  parameter  int unsigned ASID_W = 8,
  localparam int unsigned OFF_W  = tlb_pkg::PAGE_OFF_W,
  localparam int unsigned VPN_W  = VA_W - OFF_W,
  localparam int unsigned PFN_W  = PA_W - OFF_W,
  localparam int unsigned IDX_W  = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lkp_valid_i,
  input  logic [VA_W-1:0]   lkp_vaddr_i,
  input  logic [ASID_W-1:0] lkp_asid_i,
  input  logic              lkp_write_i,
  input  logic              lkp_user_i,
  output logic              lkp_ready_o,
  output logic              rsp_hit_o,
  output logic              rsp_fault_o,
  output logic [PA_W-1:0]   rsp_paddr_o,
  output logic              walk_req_o,
  output logic [VPN_W-1:0]  walk_vpn_o,
  output logic [ASID_W-1:0] walk_asid_o,
  input  logic              fill_valid_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic [PFN_W-1:0]  fill_pfn_i,
  input  logic              fill_writable_i,
  input  logic              fill_user_i,
  input  logic              fill_fault_i,
  input  logic              inv_valid_i,
  input  logic [VPN_W-1:0]  inv_vpn_i,
  input  logic [ASID_W-1:0] inv_asid_i,
  input  logic              flush_i
);
  import tlb_pkg::*;

  logic [N-1:0]              valid_q;
  logic [N-1:0][VPN_W-1:0]   vpn_q;
  logic [N-1:0][ASID_W-1:0]  asid_q;
  logic [N-1:0][PFN_W-1:0]   pfn_q;
  perm_t [N-1:0]             perm_q;

  logic [VPN_W-1:0] lkp_vpn;
  logic [N-1:0]     lkp_vec, fill_vec, inv_vec;
  logic             lkp_fire, lkp_any;
  logic [PFN_W-1:0] sel_pfn;
  perm_t            sel_perm;

  assign lkp_vpn     = lkp_vaddr_i[VA_W-1:OFF_W];
  assign lkp_ready_o = !walk_req_o;
  assign lkp_fire    = lkp_valid_i && lkp_ready_o;

  tlb_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lkp_match (
    .en_i(lkp_fire), .valid_i(valid_q), .vpn_i(vpn_q), .asid_i(asid_q),
    .key_vpn_i(lkp_vpn), .key_asid_i(lkp_asid_i), .hit_o(lkp_vec));

  tlb_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fill_match (
    .en_i(fill_valid_i), .valid_i(valid_q), .vpn_i(vpn_q), .asid_i(asid_q),
    .key_vpn_i(fill_vpn_i), .key_asid_i(fill_asid_i), .hit_o(fill_vec));

  tlb_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_inv_match (
    .en_i(inv_valid_i), .valid_i(valid_q), .vpn_i(vpn_q), .asid_i(asid_q),
    .key_vpn_i(inv_vpn_i), .key_asid_i(inv_asid_i), .hit_o(inv_vec));

  // one-hot select by OR reduction
  always_comb begin
    sel_pfn  = '0;
    sel_perm = '0;
    for (int i = 0; i < N; i++) begin
      if (lkp_vec[i]) begin
        sel_pfn  = sel_pfn | pfn_q[i];
        sel_perm = sel_perm | perm_q[i];
      end
    end
  end

  assign lkp_any     = |lkp_vec;
  assign rsp_hit_o   = lkp_fire && lkp_any;
  assign rsp_fault_o = rsp_hit_o &&
                       ((lkp_write_i && !sel_perm.wr) || (lkp_user_i && !sel_perm.usr));
  assign rsp_paddr_o = rsp_hit_o ? {sel_pfn, lkp_vaddr_i[OFF_W-1:0]} : '0;

  // walk request
  logic walk_done;
  assign walk_done = fill_valid_i && walk_req_o &&
                     (fill_vpn_i == walk_vpn_o) && (fill_asid_i == walk_asid_o);

  tlb_walk_ctl #(.VPN_W(VPN_W), .ASID_W(ASID_W)) u_walk (
    .clk_i, .rst_ni,
    .start_i(lkp_fire && !lkp_any), .start_vpn_i(lkp_vpn), .start_asid_i(lkp_asid_i),
    .done_i(walk_done), .pending_o(walk_req_o), .vpn_o(walk_vpn_o), .asid_o(walk_asid_o));

  // install target: existing tag first, else victim
  logic             install, present;
  logic [IDX_W-1:0] hit_idx, vic_idx, tgt_idx;

  assign install = fill_valid_i && !fill_fault_i;
  assign present = |fill_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N; i++)
      if (fill_vec[i]) hit_idx = IDX_W'(i);
  end

  tlb_victim #(.N(N)) u_victim (
    .clk_i, .rst_ni, .valid_i(valid_q), .alloc_i(install && !present), .idx_o(vic_idx));

  assign tgt_idx = present ? hit_idx : vic_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (flush_i) valid_q <= '0;
    else begin
      for (int i = 0; i < N; i++)
        valid_q[i] <= (valid_q[i] && !inv_vec[i]) || (install && tgt_idx == IDX_W'(i));
    end
  end

  always_ff @(posedge clk_i) begin
    if (install) begin
      vpn_q[tgt_idx]  <= fill_vpn_i;
      asid_q[tgt_idx] <= fill_asid_i;
      pfn_q[tgt_idx]  <= fill_pfn_i;
      perm_q[tgt_idx] <= '{wr: fill_writable_i, usr: fill_user_i};
    end
  end

  // R8
  single_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lkp_vec));

  // R7
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_q == '0));

  // R4
  fill_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (install && !flush_i) |=> valid_q[$past(tgt_idx)]);
endmodule

// File: tb/asid_tlb_tb.sv
`timescale 1ns/1ps
module asid_tlb_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        lkp_valid = 0, lkp_write = 0, lkp_user = 0;
  logic [31:0] lkp_vaddr = '0;
  logic [7:0]  lkp_asid = '0;
  logic        lkp_ready, rsp_hit, rsp_fault;
  logic [31:0] rsp_paddr;
  logic        walk_req;
  logic [19:0] walk_vpn;
  logic [7:0]  walk_asid;
  logic        fill_valid = 0, fill_wr = 0, fill_usr = 0, fill_flt = 0;
  logic [19:0] fill_vpn = '0, fill_pfn = '0;
  logic [7:0]  fill_asid = '0;
  logic        inv_valid = 0;
  logic [19:0] inv_vpn = '0;
  logic [7:0]  inv_asid = '0;
  logic        flush = 0;

  asid_tlb u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .lkp_valid_i(lkp_valid), .lkp_vaddr_i(lkp_vaddr), .lkp_asid_i(lkp_asid),
    .lkp_write_i(lkp_write), .lkp_user_i(lkp_user), .lkp_ready_o(lkp_ready),
    .rsp_hit_o(rsp_hit), .rsp_fault_o(rsp_fault), .rsp_paddr_o(rsp_paddr),
    .walk_req_o(walk_req), .walk_vpn_o(walk_vpn), .walk_asid_o(walk_asid),
    .fill_valid_i(fill_valid), .fill_vpn_i(fill_vpn), .fill_asid_i(fill_asid),
    .fill_pfn_i(fill_pfn), .fill_writable_i(fill_wr), .fill_user_i(fill_usr),
    .fill_fault_i(fill_flt), .inv_valid_i(inv_valid), .inv_vpn_i(inv_vpn),
    .inv_asid_i(inv_asid), .flush_i(flush));

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    logic        hit;
    logic        fault;
    logic [31:0] paddr;
    string       req;
  } exp_t;
  exp_t exp_q[$];
  event mon_ev;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected responses and compares
  initial begin
    forever begin
      @(mon_ev);
      #2;
      if (exp_q.size() != 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.req, "hit",   32'(rsp_hit),   32'(e.hit));
        chk(e.req, "fault", 32'(rsp_fault), 32'(e.fault));
        chk(e.req, "paddr", rsp_paddr,      e.paddr);
      end
    end
  end

  task automatic lookup(logic [31:0] va, logic [7:0] asid, logic wr, logic usr,
                        logic eh, logic ef, logic [31:0] ep, string req);
    @(negedge clk);
    lkp_valid = 1; lkp_vaddr = va; lkp_asid = asid; lkp_write = wr; lkp_user = usr;
    exp_q.push_back('{eh, ef, ep, req});
    ->mon_ev;
    @(posedge clk); #1 lkp_valid = 0;
  endtask

  task automatic fill(logic [19:0] vpn, logic [7:0] asid, logic [19:0] pfn,
                      logic wr, logic usr, logic flt);
    @(negedge clk);
    fill_valid = 1; fill_vpn = vpn; fill_asid = asid; fill_pfn = pfn;
    fill_wr = wr; fill_usr = usr; fill_flt = flt;
    @(posedge clk); #1 fill_valid = 0;
  endtask

  task automatic expect_walk(logic [19:0] vpn, logic [7:0] asid, string req);
    @(negedge clk); #2;
    chk(req, "walk_req",  32'(walk_req),  32'd1);
    chk(req, "walk_vpn",  32'(walk_vpn),  32'(vpn));
    chk(req, "walk_asid", 32'(walk_asid), 32'(asid));
    chk(req, "ready",     32'(lkp_ready), 32'd0);
  endtask

  // miss then walker fault answer
  task automatic miss_fault(logic [31:0] va, logic [7:0] asid, string req);
    lookup(va, asid, 0, 0, 0, 0, 32'h0, req);
    expect_walk(va[31:12], asid, req);
    fill(va[31:12], asid, 20'h0, 0, 0, 1);
    @(negedge clk); #2;
    chk(req, "ready_after", 32'(lkp_ready), 32'd1);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    // R11
    chk("R11", "walk_req", 32'(walk_req),  32'd0);
    chk("R11", "ready",    32'(lkp_ready), 32'd1);
    miss_fault(32'h0000_5000, 8'd1, "R11");

    // R1 R4: install and hit
    fill(20'h12345, 8'd3, 20'hABCDE, 1, 1, 0);
    lookup(32'h1234_5678, 8'd3, 0, 1, 1, 0, 32'hABCD_E678, "R1");

    // R2 R3: same page, other identifier misses, walker answers
    lookup(32'h1234_5678, 8'd4, 0, 1, 0, 0, 32'h0, "R2");
    expect_walk(20'h12345, 8'd4, "R3");
    fill(20'h12345, 8'd4, 20'h11111, 1, 1, 0);
    lookup(32'h1234_5678, 8'd4, 0, 1, 1, 0, 32'h1111_1678, "R4");
    lookup(32'h1234_5678, 8'd3, 0, 1, 1, 0, 32'hABCD_E678, "R2");

    // R5 permissions
    fill(20'h00040, 8'd3, 20'h00777, 0, 0, 0);
    lookup(32'h0004_0ABC, 8'd3, 0, 0, 1, 0, 32'h0077_7ABC, "R5");
    lookup(32'h0004_0ABC, 8'd3, 1, 0, 1, 1, 32'h0077_7ABC, "R5");
    lookup(32'h0004_0ABC, 8'd3, 0, 1, 1, 1, 32'h0077_7ABC, "R5");
    fill(20'h00041, 8'd3, 20'h00888, 0, 1, 0);
    lookup(32'h0004_1010, 8'd3, 0, 1, 1, 0, 32'h0088_8010, "R5");
    lookup(32'h0004_1010, 8'd3, 1, 1, 1, 1, 32'h0088_8010, "R5");

    // R10 R3: stall while walk open, unrelated fill does not end it
    lookup(32'h0009_9000, 8'd3, 0, 0, 0, 0, 32'h0, "R10");
    lookup(32'h1234_5678, 8'd3, 0, 1, 0, 0, 32'h0, "R10");
    expect_walk(20'h00099, 8'd3, "R10");
    fill(20'h00050, 8'd3, 20'h00500, 1, 1, 0);
    expect_walk(20'h00099, 8'd3, "R3");
    fill(20'h00099, 8'd3, 20'h0, 0, 0, 1);
    // R4 fault answer installed nothing
    miss_fault(32'h0009_9000, 8'd3, "R4");

    // R8 overwrite
    fill(20'h00050, 8'd3, 20'h0000A, 1, 1, 0);
    lookup(32'h0005_0000, 8'd3, 0, 0, 1, 0, 32'h0000_A000, "R8");

    // R6 targeted invalidate
    @(negedge clk);
    inv_valid = 1; inv_vpn = 20'h12345; inv_asid = 8'd4;
    @(posedge clk); #1 inv_valid = 0;
    lookup(32'h1234_5678, 8'd3, 0, 1, 1, 0, 32'hABCD_E678, "R6");
    miss_fault(32'h1234_5678, 8'd4, "R6");

    // R9: slots 0,2,3,4 used; free 1,5,6,7 then round robin from 0
    fill(20'h00060, 8'd3, 20'h00060, 1, 1, 0);
    fill(20'h00070, 8'd3, 20'h00070, 1, 1, 0);
    fill(20'h00080, 8'd3, 20'h00080, 1, 1, 0);
    fill(20'h00090, 8'd3, 20'h00090, 1, 1, 0);
    lookup(32'h0006_0000, 8'd3, 0, 0, 1, 0, 32'h0006_0000, "R9");
    fill(20'h000A0, 8'd3, 20'h000A0, 1, 1, 0);
    miss_fault(32'h1234_5678, 8'd3, "R9");
    lookup(32'h0006_0000, 8'd3, 0, 0, 1, 0, 32'h0006_0000, "R9");
    fill(20'h000B0, 8'd3, 20'h000B0, 1, 1, 0);
    miss_fault(32'h0006_0000, 8'd3, "R9");
    lookup(32'h0004_0ABC, 8'd3, 0, 0, 1, 0, 32'h0077_7ABC, "R9");
    lookup(32'h000A_0000, 8'd3, 0, 0, 1, 0, 32'h000A_0000, "R9");

    // R7 flush
    @(negedge clk);
    flush = 1;
    @(posedge clk); #1 flush = 0;
    miss_fault(32'h0004_0ABC, 8'd3, "R7");
    miss_fault(32'h000B_0000, 8'd3, "R7");
    fill(20'h000C0, 8'd3, 20'h000C0, 1, 1, 0);
    lookup(32'h000C_0004, 8'd3, 0, 0, 1, 0, 32'h000C_0004, "R7");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL monitor left %0d expected items", exp_q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule